// File: doc/BRIEF.md
# Receiver Error Flag Generator

This block drives the single error output of a digital audio receiver. It gathers the error sources that the receiver front end reports: a lock-loss level from clock recovery, a per-frame parity strobe, a strobe for changed format information, and a sample-rate code measured once per frame. It merges them into one flag. Any error sets the flag on the next clock edge. After the last error the flag stays set for a programmable number of frames, and it only clears on a frame boundary. Downstream logic therefore sees a clean source before it trusts the audio.

A mode input turns the same output into a mute indicator for the audio data path. The error flag itself is always available on a separate status output. The hold length is 576 frames or 1152 frames. At every common sample rate from 32 kHz to 192 kHz this gives a release delay of roughly 3 ms to 36 ms.

Top module: `audio_err_flag`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `flag_o` and `status_o` are 1. The hold counter starts cleared, so a full hold must elapse even if no error is ever reported.
- R2: `lock_err_i` high at a clock edge makes `status_o` 1 after that edge and keeps it there while the level lasts.
- R3: A one-cycle `parity_err_i` strobe makes `status_o` 1 after that edge.
- R4: A one-cycle `fmt_err_i` strobe makes `status_o` 1 after that edge.
- R5: A frame edge is a clock edge at which `lrck_i` is 1 and was 0 at the previous edge. At a frame edge where lock is held and was also held at the previous frame edge, a `rate_i` value that differs from the value captured at that previous frame edge counts as an error.
- R6: With `hold_long_i` = 0 when the hold is loaded, `status_o` falls at the 576th frame edge after the last error cycle, and not earlier.
- R7: With `hold_long_i` = 1 when the hold is loaded, the release happens at the 1152nd frame edge.
- R8: An error during a running hold restarts the full hold count.
- R9: With `mode_sel_i` = 1 (mute mode), `flag_o` equals the value `mute_i` had at the previous edge, and `status_o` still shows the error flag. With `mode_sel_i` = 0, `flag_o` equals `status_o`.
- R10: `status_o` only falls on a frame edge.
- R11: A change of `rate_i` is not an error while lock is lost, nor at the first frame edge after lock returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_err_i | input | 1 | Clock recovery is unlocked (level) |
| parity_err_i | input | 1 | Parity error in the current frame (strobe) |
| fmt_err_i | input | 1 | Change in format information detected (strobe) |
| lrck_i | input | 1 | Frame clock, rising edge starts a frame |
| rate_i | input | RATE_W | Measured sample-rate code |
| mute_i | input | 1 | Audio data output is muted |
| mode_sel_i | input | 1 | 0: error flag on `flag_o`, 1: mute status on `flag_o` |
| hold_long_i | input | 1 | 0: 576-frame hold, 1: 1152-frame hold |
| flag_o | output | 1 | Registered error or mute output |
| status_o | output | 1 | Registered error flag, readable in any mode |

## Verification
The hardest case to reach is an error that lands late in a running hold, because it only shows when the release happens a full hold later instead of at the first count. The stimulus reaches it with long frame-counted runs and directed strobes placed in the middle of a hold. A random phase then scatters errors, rate changes, hold-length changes and mode switches across many holds. A per-cycle reference model in the bench tracks the expected flag through all of this.

// File: rtl/aef_pkg.sv
package aef_pkg;
  typedef enum logic {
    OUT_ERROR = 1'b0,
    OUT_MUTE  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/aef_frame_edge.sv
module aef_frame_edge (
  input  logic clk,
  input  logic rst,
  input  logic lrck_i,
  output logic tick_o
);
  logic lrck_q;

  always_ff @(posedge clk) begin
    if (rst) lrck_q <= 1'b0;
    else     lrck_q <= lrck_i;
  end

  assign tick_o = lrck_i & ~lrck_q;
endmodule

// File: rtl/aef_rate_watch.sv
module aef_rate_watch #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              lock_err_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              mismatch_o
);
  logic [RATE_W-1:0] rate_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (lock_err_i)  valid_q <= 1'b0;
      else if (tick_i) valid_q <= 1'b1;
      if (tick_i)      rate_q  <= rate_i;
    end
  end

  assign mismatch_o = tick_i & valid_q & ~lock_err_i & (rate_i != rate_q);
endmodule

// File: rtl/aef_hold_ctr.sv
module aef_hold_ctr #(
  parameter int HOLD_SHORT = 576,
  parameter int HOLD_LONG  = 1152
) (
  input  logic clk,
  input  logic rst,
  input  logic err_i,
  input  logic tick_i,
  input  logic long_i,
  output logic flag_nxt_o,
  output logic flag_o
);
  localparam int CNT_W = $clog2(HOLD_LONG + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n, len;
  logic             flag_q, flag_n;

  assign len = long_i ? CNT_W'(HOLD_LONG) : CNT_W'(HOLD_SHORT);

  always_comb begin
    flag_n = flag_q;
    cnt_n  = cnt_q;
    if (err_i) begin
      flag_n = 1'b1;
      cnt_n  = len;
    end else if (flag_q) begin
      if (cnt_q == '0) begin
        cnt_n = len;
      end else if (tick_i) begin
        if (cnt_q == CNT_W'(1)) begin
          flag_n = 1'b0;
          cnt_n  = '0;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_n;
      cnt_q  <= cnt_n;
    end
  end

  assign flag_nxt_o = flag_n;
  assign flag_o     = flag_q;
endmodule

// File: rtl/audio_err_flag.sv
module audio_err_flag
  import aef_pkg::*;
#(
  parameter int RATE_W     = 4,
  parameter int HOLD_SHORT = 576,
  parameter int HOLD_LONG  = 1152
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_err_i,
  input  logic              parity_err_i,
  input  logic              fmt_err_i,
  input  logic              lrck_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              mute_i,
  input  logic              mode_sel_i,
  input  logic              hold_long_i,
  output logic              flag_o,
  output logic              status_o
);
  logic      tick, rate_bad, any_err, err_nxt;
  out_mode_e mode;

  assign mode = out_mode_e'(mode_sel_i);

  aef_frame_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lrck_i (lrck_i),
    .tick_o (tick)
  );

  aef_rate_watch #(.RATE_W(RATE_W)) u_rate (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .lock_err_i (lock_err_i),
    .rate_i     (rate_i),
    .mismatch_o (rate_bad)
  );

  assign any_err = lock_err_i | parity_err_i | fmt_err_i | rate_bad;

  aef_hold_ctr #(.HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .err_i      (any_err),
    .tick_i     (tick),
    .long_i     (hold_long_i),
    .flag_nxt_o (err_nxt),
    .flag_o     (status_o)
  );

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b1;
    else     flag_o <= (mode == OUT_MUTE) ? mute_i : err_nxt;
  end
endmodule

// File: rtl/audio_err_flag_chk.sv
module audio_err_flag_chk #(
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              lock_err_i,
  input logic              parity_err_i,
  input logic              fmt_err_i,
  input logic              lrck_i,
  input logic [RATE_W-1:0] rate_i,
  input logic              mute_i,
  input logic              mode_sel_i,
  input logic              hold_long_i,
  input logic              flag_o,
  input logic              status_o
);
  a_r2_lock_sets: assert property (@(posedge clk) disable iff (rst)
    lock_err_i |=> status_o);

  a_r3_parity_sets: assert property (@(posedge clk) disable iff (rst)
    parity_err_i |=> status_o);

  a_r4_fmt_sets: assert property (@(posedge clk) disable iff (rst)
    fmt_err_i |=> status_o);

  a_r9_mute_follow: assert property (@(posedge clk) disable iff (rst)
    mode_sel_i |=> (flag_o == $past(mute_i)));

  a_r9_err_follow: assert property (@(posedge clk) disable iff (rst)
    !mode_sel_i |=> (flag_o == status_o));

  a_r10_fall_on_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o) |-> ($past(lrck_i) && !$past(lrck_i, 2)));
endmodule

bind audio_err_flag audio_err_flag_chk #(.RATE_W(RATE_W)) u_chk (.*);

// File: tb/audio_err_flag_tb.sv
`timescale 1ns/1ps
module audio_err_flag_tb;
  localparam int RW = 4;
  localparam int HS = 576;
  localparam int HL = 1152;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock = 1'b0, par = 1'b0, fmt = 1'b0, lrck = 1'b0;
  logic [RW-1:0] rate = 4'd3;
  logic mute = 1'b0, mode = 1'b0, hlong = 1'b0;
  logic flag_o, status_o;

  int checks = 0, failures = 0, fcnt = 0;
  bit done = 1'b0;
  string g_tag = "R1";

  // reference model state
  logic m_flag, m_out, m_rv, m_lprev;
  logic [RW-1:0] m_rprev;
  int m_left;

  always #2.5 clk = ~clk;

  audio_err_flag #(.RATE_W(RW), .HOLD_SHORT(HS), .HOLD_LONG(HL)) u_dut (
    .clk(clk), .rst(rst), .lock_err_i(lock), .parity_err_i(par),
    .fmt_err_i(fmt), .lrck_i(lrck), .rate_i(rate), .mute_i(mute),
    .mode_sel_i(mode), .hold_long_i(hlong), .flag_o(flag_o), .status_o(status_o)
  );

  function automatic int hold_len(logic lng);
    return lng ? HL : HS;
  endfunction

  always @(posedge clk) begin
    logic tk, rerr, err;
    if (rst) begin
      m_flag = 1'b1; m_out = 1'b1; m_left = 0;
      m_rv = 1'b0; m_lprev = 1'b0; m_rprev = '0;
    end else begin
      tk = lrck && !m_lprev;
      m_lprev = lrck;
      rerr = tk && m_rv && !lock && (rate != m_rprev);
      if (lock)    m_rv = 1'b0;
      else if (tk) m_rv = 1'b1;
      if (tk) m_rprev = rate;
      err = lock || par || fmt || rerr;
      if (err) begin
        m_flag = 1'b1; m_left = hold_len(hlong);
      end else if (m_flag) begin
        if (m_left == 0) m_left = hold_len(hlong);
        else if (tk) begin
          if (m_left == 1) begin m_flag = 1'b0; m_left = 0; end
          else m_left = m_left - 1;
        end
      end
      m_out = mode ? mute : m_flag;
    end
  end

  task automatic chk(string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", g_tag, what, got, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (!rst) begin
      chk("flag_o", flag_o, m_out);
      chk("status_o", status_o, m_flag);
    end
    fcnt++;
    lrck = (fcnt % 8) < 4;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  // count frames from now until status falls; returns frame edges seen
  task automatic frames_to_release(output int nf);
    logic prev;
    nf = 0;
    prev = lrck;
    for (int i = 0; i < 20000; i++) begin
      cyc();
      if (lrck && !prev) nf++;
      prev = lrck;
      if (!status_o) break;
    end
  endtask

  initial begin
    int nf;
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    g_tag = "R1";
    chk("flag_o in reset R1", flag_o, 1'b1);
    chk("status_o in reset R1", status_o, 1'b1);
    rst = 1'b0;
    cyc();
    chk("flag_o after reset R1", flag_o, 1'b1);

    // R11 path of reset: full hold with no error ever reported (R6 length)
    g_tag = "R6";
    run(HS * 8 + 40);
    chk("released after reset hold R6", status_o, 1'b0);

    // R2: lock loss
    g_tag = "R2";
    lock = 1'b1; cyc();
    chk("lock raises R2", status_o, 1'b1);
    run(30); lock = 1'b0;
    g_tag = "R6";
    frames_to_release(nf);
    checks++;
    if (nf < HS - 1 || nf > HS + 1) begin
      failures++;
      $display("FAIL R6 frame count: got %0d expected about %0d", nf, HS);
    end
    run(20);

    // R7: long hold after parity strobe (R3)
    g_tag = "R3";
    hlong = 1'b1; par = 1'b1; cyc(); par = 1'b0;
    chk("parity raises R3", status_o, 1'b1);
    g_tag = "R7";
    run(HS * 8 + 40);
    chk("still held past short hold R7", status_o, 1'b1);
    run((HL - HS) * 8);
    chk("released after long hold R7", status_o, 1'b0);
    hlong = 1'b0;

    // R4 then R8: format strobe, then new error mid-hold restarts count
    g_tag = "R4";
    fmt = 1'b1; cyc(); fmt = 1'b0;
    chk("fmt raises R4", status_o, 1'b1);
    g_tag = "R8";
    run(HS * 4);
    par = 1'b1; cyc(); par = 1'b0;
    run(HS * 4 + 40);
    chk("hold restarted R8", status_o, 1'b1);
    run(HS * 4);
    chk("released after restart R8", status_o, 1'b0);

    // R5: rate change while locked is an error
    g_tag = "R5";
    run(16);
    rate = 4'd5;
    run(10);
    chk("rate change raises R5", status_o, 1'b1);
    run(HS * 8 + 40);

    // R11: rate change during and right after lock loss is ignored
    g_tag = "R11";
    lock = 1'b1; run(12);
    rate = 4'd7; run(12);
    lock = 1'b0; rate = 4'd9; run(HS * 8 + 60);
    chk("no rate error around relock R11", status_o, 1'b0);

    // R9: mute mode
    g_tag = "R9";
    mode = 1'b1;
    for (int i = 0; i < 200; i++) begin
      mute = 1'($urandom % 2);
      if (i == 50) begin par = 1'b1; cyc(); par = 1'b0; end
      else cyc();
    end
    chk("status kept in mute mode R9", status_o, 1'b1);
    mode = 1'b0; mute = 1'b0;
    run(HS * 8 + 40);

    // R10 / mixed random phase
    g_tag = "R10";
    for (int i = 0; i < 60000; i++) begin
      int r;
      r = int'($urandom % 10000);
      par = (r < 2);
      fmt = (r >= 2 && r < 3);
      if (r >= 3 && r < 5) lock = ~lock;
      if (r >= 5 && r < 7) rate = RW'($urandom);
      if (r >= 7 && r < 9) hlong = ~hlong;
      if (r >= 9 && r < 10) mode = ~mode;
      mute = ($urandom % 4) == 0;
      cyc();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule